// File: doc/BRIEF.md
# Flash Embedded-Operation Status Flag Generator

This block is the device-side logic that a parallel NOR-style flash uses to report how its internal program and erase algorithms are doing. A host polls the part with status reads, and each read returns a byte whose upper bits carry progress flags. Bit 7 is a polling bit: it shows the inverted target data while the algorithm runs and the true data once it is finished. Two toggle bits (6 and 2) flip on successive reads, and each has its own mode and sector qualifiers. Bit 5 latches a failure when the algorithm runs out of pulses. Bit 3 shows whether the window for adding more sectors to an erase is still open.

The operation mode comes from the command decoder, which is outside this block. The decoder also supplies the read strobe, a flag for reads that hit a sector being erased, bit 7 of the target data, a tick per algorithm pulse, a completion request, an additional-sector-erase command and a reset command. Pulses are counted inside the block. The erase window is a counter restarted by each accepted additional-sector command. The block answers each additional-sector command on `se_ack` in the following cycle. Mode encoding on `op_mode` is 0 idle, 1 programming, 2 erasing, 3 erase-suspended read and 4 erase-suspended program. Any other code acts as idle.

Top module: `flsts_status_gen`

## Requirements
- R1: During and right after synchronous reset, `status` is 8'h00 and `se_ack` is 0.
- R2: Status bit 7 returns the complement of `tgt_d7` while busy and `tgt_d7` itself otherwise. Busy means the failure latch is set, or the mode is 1, 2 or 4 and the current operation has not completed.
- R3: Bit 5 stays 0 through MAX_PULSES pulse ticks of one operation and becomes 1 on the next tick. It counts only in modes 1, 2 and 4 while the operation is still running.
- R4: Once bit 5 is 1, the completion request has no effect, reads keep toggling bit 6, and bit 7 stays inverted. This holds in every mode until `abort_cmd` clears the latch.
- R5: In modes 1 and 4, a completion request is ignored while `tgt_blank` is 0, so programming a non-blank target can only end in the bit-5 failure.
- R6: Bit 6 inverts on each read in modes 1, 2 and 4 while busy, and on each read while failed. Otherwise it holds its last value.
- R7: Bit 2 inverts on each read with `rd_in_erase` set, in mode 2 while busy and in mode 3. Otherwise it holds.
- R8: In mode 4, a read with `rd_in_erase` clear returns 1 on bit 2.
- R9: Bit 3 reads 0 for WIN_LEN cycles after mode 2 is entered, then reads 1. It stays 1 through modes 3 and 4 and clears in any other mode.
- R10: An `se_cmd` in mode 2 while bit 3 is 0 restarts the window and gives `se_ack` = 1 one cycle later. When bit 3 is 1 the command is ignored: `se_ack` stays 0 and the window does not move.
- R11: `status` is loaded only on a cycle with `rd_stb` high, and is visible after that clock edge. Bits 4, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 3 | Operation mode code (0..4) |
| rd_stb | input | 1 | Status read strobe, one cycle per read |
| rd_in_erase | input | 1 | Read address lies in an erasing or erase-suspended sector |
| tgt_d7 | input | 1 | Bit 7 of the data being programmed or of the read location |
| tgt_blank | input | 1 | Program target location is erased |
| pulse_tick | input | 1 | One internal algorithm pulse applied |
| done_req | input | 1 | Algorithm reports successful completion |
| se_cmd | input | 1 | Additional sector-erase command |
| abort_cmd | input | 1 | Reset command: clears failure, counters and window |
| status | output | 8 | Registered status byte |
| se_ack | output | 1 | Additional sector-erase command accepted |

## Verification
The assertions assume that `op_mode` only takes codes 0 to 4, and that the decoder never jumps straight from an active operation into a new one without passing through idle or `abort_cmd`. The stimulus changes `op_mode` only between reads and goes back to idle between programming runs. It raises `abort_cmd` only to leave the locked state. Pulse ticks, completion requests and erase commands are held on full clock cycles and driven on the falling edge, so every flag the design registers is in a known state before the next read.

// File: rtl/flsts_pkg.sv
package flsts_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSP_RD = 3'd3,
    OP_SUSP_PG = 3'd4
  } op_mode_e;

  localparam int unsigned NUM_TOGGLES = 2;
  localparam int unsigned TOG_B6 = 0;
  localparam int unsigned TOG_B2 = 1;
endpackage

// File: rtl/flsts_toggle.sv
module flsts_toggle (
  input  logic clk,
  input  logic rst,
  input  logic rd_stb,
  input  logic qual,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)                q <= 1'b0;
    else if (rd_stb && qual) q <= ~q;
  end

  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && qual) |=> $stable(q)); // R6

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && qual) |=> (q != $past(q))); // R7
endmodule

// File: rtl/flsts_fail.sv
module flsts_fail #(
  parameter int unsigned MAX_PULSES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic is_prog,
  input  logic is_idle,
  input  logic tgt_blank,
  input  logic pulse_tick,
  input  logic done_req,
  input  logic abort_cmd,
  output logic fail,
  output logic done
);
  localparam int unsigned CW = $clog2(MAX_PULSES + 1);

  logic [CW-1:0] cnt;
  logic          running;
  logic          may_finish;

  assign running    = active && !done && !fail;
  assign may_finish = !is_prog || tgt_blank;

  always_ff @(posedge clk) begin
    if (rst || abort_cmd) begin
      cnt  <= '0;
      fail <= 1'b0;
      done <= 1'b0;
    end else if (is_idle) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (running) begin
      if (done_req && may_finish) begin
        done <= 1'b1;
      end else if (pulse_tick) begin
        if (cnt == CW'(MAX_PULSES)) fail <= 1'b1;
        else                        cnt  <= cnt + 1'b1;
      end
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && !abort_cmd) |=> fail); // R4

  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> ($past(cnt) == CW'(MAX_PULSES))); // R3

  AST_NONBLANK_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (is_prog && !tgt_blank && !done && !abort_cmd) |=> !done); // R5
endmodule

// File: rtl/flsts_window.sv
module flsts_window #(
  parameter int unsigned WIN_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_erase,
  input  logic erase_family,
  input  logic se_cmd,
  input  logic abort_cmd,
  output logic closed,
  output logic se_ack
);
  localparam int unsigned WW = $clog2(WIN_LEN + 1);

  logic [WW-1:0] wcnt;
  logic          take;

  assign take = in_erase && !closed && se_cmd;

  always_ff @(posedge clk) begin
    if (rst) se_ack <= 1'b0;
    else     se_ack <= take && !abort_cmd;
  end

  always_ff @(posedge clk) begin
    if (rst || abort_cmd || !erase_family) begin
      wcnt   <= '0;
      closed <= 1'b0;
    end else if (in_erase && !closed) begin
      if (se_cmd)                           wcnt   <= '0;
      else if (wcnt == WW'(WIN_LEN - 1))   closed <= 1'b1;
      else                                  wcnt   <= wcnt + 1'b1;
    end
  end

  AST_NO_ACK_CLOSED: assert property (@(posedge clk) disable iff (rst)
    closed |=> !se_ack); // R10

  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (closed && erase_family && !abort_cmd) |=> closed); // R9
endmodule

// File: rtl/flsts_status_gen.sv
module flsts_status_gen
  import flsts_pkg::*;
#(
  parameter int unsigned MAX_PULSES = 20,
  parameter int unsigned WIN_LEN    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] op_mode,
  input  logic       rd_stb,
  input  logic       rd_in_erase,
  input  logic       tgt_d7,
  input  logic       tgt_blank,
  input  logic       pulse_tick,
  input  logic       done_req,
  input  logic       se_cmd,
  input  logic       abort_cmd,
  output logic [7:0] status,
  output logic       se_ack
);
  logic m_prog, m_erase, m_srd, m_spg, m_idle;
  logic active, is_prog, erase_family;
  logic fail, done, busy, closed;
  logic [NUM_TOGGLES-1:0] qual;
  logic [NUM_TOGGLES-1:0] tog;
  logic b2_next;

  always_comb begin
    m_prog  = (op_mode == OP_PROG);
    m_erase = (op_mode == OP_ERASE);
    m_srd   = (op_mode == OP_SUSP_RD);
    m_spg   = (op_mode == OP_SUSP_PG);
    m_idle  = !(m_prog || m_erase || m_srd || m_spg);
  end

  assign active       = m_prog || m_erase || m_spg;
  assign is_prog      = m_prog || m_spg;
  assign erase_family = m_erase || m_srd || m_spg;
  assign busy         = fail || (active && !done);

  assign qual[TOG_B6] = busy;
  assign qual[TOG_B2] = rd_in_erase && ((m_erase && busy) || m_srd);

  flsts_fail #(.MAX_PULSES(MAX_PULSES)) u_fail (
    .clk(clk), .rst(rst), .active(active), .is_prog(is_prog),
    .is_idle(m_idle), .tgt_blank(tgt_blank), .pulse_tick(pulse_tick),
    .done_req(done_req), .abort_cmd(abort_cmd), .fail(fail), .done(done)
  );

  flsts_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst(rst), .in_erase(m_erase), .erase_family(erase_family),
    .se_cmd(se_cmd), .abort_cmd(abort_cmd), .closed(closed), .se_ack(se_ack)
  );

  for (genvar g = 0; g < NUM_TOGGLES; g++) begin : g_tog
    flsts_toggle u_tog (
      .clk(clk), .rst(rst), .rd_stb(rd_stb), .qual(qual[g]), .q(tog[g])
    );
  end

  assign b2_next = (m_spg && !rd_in_erase) ? 1'b1 : (tog[TOG_B2] ^ qual[TOG_B2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 8'h00;
    end else if (rd_stb) begin
      status <= {busy ? ~tgt_d7 : tgt_d7,
                 tog[TOG_B6] ^ qual[TOG_B6],
                 fail,
                 1'b0,
                 closed,
                 b2_next,
                 2'b00};
    end
  end

  AST_STATUS_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(status)); // R11

  AST_SUSP_PG_B2: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && m_spg && !rd_in_erase) |=> status[2]); // R8

  AST_FAIL_B7_INV: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && fail) |=> (status[7] == !$past(tgt_d7))); // R2

  AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status[4] == 1'b0) && (status[1:0] == 2'b00)); // R11
endmodule

// File: tb/flsts_status_gen_test.sv
module flsts_status_gen_test;
  localparam int unsigned MAXP = 20;
  localparam int unsigned WLEN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] op_mode = 3'd0;
  logic rd_stb = 0, rd_in_erase = 0, tgt_d7 = 0, tgt_blank = 1;
  logic pulse_tick = 0, done_req = 0, se_cmd = 0, abort_cmd = 0;
  logic [7:0] status;
  logic se_ack;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  flsts_status_gen #(.MAX_PULSES(MAXP), .WIN_LEN(WLEN)) uut (
    .clk(clk), .rst(rst), .op_mode(op_mode), .rd_stb(rd_stb),
    .rd_in_erase(rd_in_erase), .tgt_d7(tgt_d7), .tgt_blank(tgt_blank),
    .pulse_tick(pulse_tick), .done_req(done_req), .se_cmd(se_cmd),
    .abort_cmd(abort_cmd), .status(status), .se_ack(se_ack)
  );

  function automatic logic [7:0] mk(logic b7, logic b6, logic b5, logic b3, logic b2);
    return {b7, b6, b5, 1'b0, b3, b2, 2'b00};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // driver: one read per call, expected byte goes to the scoreboard
  task automatic do_read(logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  // monitor: compares status after each read edge
  initial begin
    forever begin
      @(posedge clk);
      if (rd_stb) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk("scoreboard underflow", status, 8'hxx);
        end else begin
          chk(tag_q.pop_front(), status, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic e6, e2;
    e6 = 0; e2 = 0;
    repeat (3) @(negedge clk);
    chk("R1 status in reset", status, 8'h00);
    chk("R1 se_ack in reset", {7'd0, se_ack}, 8'h00);
    rst = 0;
    @(negedge clk);
    chk("R1 status after reset", status, 8'h00);

    // idle reads: true data, no toggling
    tgt_d7 = 1;
    do_read(mk(1, 0, 0, 0, 0), "R6 idle read holds b6 / R2 true data");
    do_read(mk(1, 0, 0, 0, 0), "R6 idle second read");
    repeat (3) @(negedge clk);
    chk("R11 status stable without reads", status, mk(1, 0, 0, 0, 0));

    // programming a blank location
    op_mode = 3'd1;
    e6 = ~e6; do_read(mk(0, e6, 0, 0, 0), "R2 R6 program busy read 1");
    e6 = ~e6; do_read(mk(0, e6, 0, 0, 0), "R6 program busy read 2");
    e6 = ~e6; do_read(mk(0, e6, 0, 0, 0), "R6 program busy read 3");
    done_req = 1; @(negedge clk); done_req = 0;
    do_read(mk(1, e6, 0, 0, 0), "R2 R6 program done true data");
    do_read(mk(1, e6, 0, 0, 0), "R6 program done holds");

    // non-blank program ends in timeout
    op_mode = 3'd0; @(negedge clk);
    op_mode = 3'd1; tgt_blank = 0; tgt_d7 = 0; done_req = 1;
    pulse_tick = 1;
    repeat (MAXP) @(negedge clk);
    pulse_tick = 0;
    e6 = ~e6; do_read(mk(1, e6, 0, 0, 0), "R3 R5 no fail at limit");
    pulse_tick = 1; @(negedge clk); pulse_tick = 0;
    e6 = ~e6; do_read(mk(1, e6, 1, 0, 0), "R3 fail after limit");
    tgt_blank = 1; @(negedge clk); done_req = 0;
    e6 = ~e6; do_read(mk(1, e6, 1, 0, 0), "R4 completion ignored when failed");
    op_mode = 3'd0;
    e6 = ~e6; do_read(mk(1, e6, 1, 0, 0), "R4 locked in idle mode");
    abort_cmd = 1; @(negedge clk); abort_cmd = 0;
    do_read(mk(0, e6, 0, 0, 0), "R4 abort clears lock");

    // erase with window
    tgt_d7 = 1; rd_in_erase = 1; op_mode = 3'd2;
    e6 = ~e6; e2 = ~e2; do_read(mk(0, e6, 0, 0, e2), "R7 R9 erase entry read");
    se_cmd = 1; @(negedge clk); se_cmd = 0;
    chk("R10 se_ack while open", {7'd0, se_ack}, 8'h01);
    repeat (6) @(negedge clk);
    rd_in_erase = 0;
    e6 = ~e6; do_read(mk(0, e6, 0, 0, e2), "R10 window restarted b3 low / R7 hold");
    repeat (2) @(negedge clk);
    se_cmd = 1; @(negedge clk); se_cmd = 0;
    chk("R10 se_ack when closed", {7'd0, se_ack}, 8'h00);
    rd_in_erase = 1;
    e6 = ~e6; e2 = ~e2; do_read(mk(0, e6, 0, 1, e2), "R9 window closed b3 high");

    // erase-suspended read
    op_mode = 3'd3;
    e2 = ~e2; do_read(mk(1, e6, 0, 1, e2), "R7 suspend-read toggles b2");
    e2 = ~e2; do_read(mk(1, e6, 0, 1, e2), "R7 suspend-read toggles b2 again");
    rd_in_erase = 0;
    do_read(mk(1, e6, 0, 1, e2), "R7 suspend-read other sector holds");

    // erase-suspended program
    op_mode = 3'd4;
    e6 = ~e6; do_read(mk(0, e6, 0, 1, 1'b1), "R8 suspend-program other sector b2 one");
    rd_in_erase = 1;
    e6 = ~e6; do_read(mk(0, e6, 0, 1, e2), "R8 suspend-program suspended sector");

    op_mode = 3'd0; @(negedge clk);
    do_read(mk(1, e6, 0, 0, e2), "R9 b3 clears in idle");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard drained", 8'(exp_q.size()), 8'h00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule